// File: doc/BRIEF.md
# Start-up and Auto-Restart Sequencer

This block steers the power-up of an off-line switching converter. Its inputs are flags already digitized by analog comparators: the input bulk voltage is above the start level, the supply has reached its turn-on level, the supply has dropped below its undervoltage-off level, and the supply has dropped below its much lower restart level. A fault-shutdown request comes from the protection logic. From these, the block turns the high-voltage start-up charger on and off and selects its reduced-current setting. It also enables switching and produces a current-limit reference code that climbs from zero to full scale during soft-start.

A one-hot state machine walks through five states. ST_OFF waits for input voltage. ST_CHARGE runs the charger until the supply reaches turn-on. ST_SOFTSTART switches with a rising limit code. ST_RUN switches at the full limit. ST_WAIT_RESTART holds everything off until the supply has sagged to the restart level. The transitions are: power-present (OFF to CHARGE), input-lost (CHARGE to OFF), supply-ready (CHARGE to SOFTSTART), ramp-done (SOFTSTART to RUN), fault-stop and undervoltage-stop (SOFTSTART/RUN to WAIT_RESTART), inhibited-stop (SOFTSTART/RUN to OFF when the input is gone), restart (WAIT_RESTART to CHARGE) and restart-inhibit (WAIT_RESTART to OFF). When the stop came from a fault, the next charge uses the low current. This makes the hiccup repetition slow, and each attempt replays the soft-start ramp.

Top module: `startup_seq`

## Requirements
- R1: After reset the block is in ST_OFF with chg_en, chg_low and sw_en low and ilim_code zero, and it stays there while vin_ok is low.
- R2: In ST_OFF, vin_ok high moves to ST_CHARGE on the next clock, where chg_en is high. In ST_CHARGE, vin_ok low returns to ST_OFF on the next clock, dropping chg_en.
- R3: In ST_CHARGE, vdd_on high moves to ST_SOFTSTART on the next clock. On that same clock chg_en goes low and sw_en goes high, so the two are never high together.
- R4: In ST_SOFTSTART or ST_RUN, vdd_uvlo high with vin_ok high moves to ST_WAIT_RESTART on the next clock. There sw_en and chg_en stay low until vdd_rst is seen.
- R5: In ST_WAIT_RESTART, vdd_rst high moves to ST_CHARGE if vin_ok is high, and to ST_OFF if vin_ok is low.
- R6: In ST_SOFTSTART or ST_RUN, vdd_uvlo high with vin_ok low moves to ST_OFF, so no restart charging takes place.
- R7: In ST_SOFTSTART or ST_RUN, fault_req high (with vin_ok high or vdd_uvlo low) moves to ST_WAIT_RESTART and sets a fault-origin flag. The following ST_CHARGE then drives chg_low high. After a stop caused only by undervoltage, chg_low stays low.
- R8: The fault-origin flag clears on entry to ST_SOFTSTART and on entry to ST_OFF.
- R9: On entry to ST_SOFTSTART, ilim_code is zero. It then rises by exactly one every STEP_CLKS clocks until it reaches 2**CODE_W-1, and the state moves to ST_RUN on the following clock.
- R10: The ramp restarts from zero on every attempt, including attempts after a fault.
- R11: ilim_code is zero outside ST_SOFTSTART and ST_RUN, and is 2**CODE_W-1 in ST_RUN.
- R12: fault_req has no effect in ST_OFF, ST_CHARGE and ST_WAIT_RESTART.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_ok | input | 1 | Input bulk voltage above start level |
| vdd_on | input | 1 | Supply at or above turn-on level |
| vdd_uvlo | input | 1 | Supply below undervoltage-off level |
| vdd_rst | input | 1 | Supply below restart level |
| fault_req | input | 1 | Fault-shutdown request from protections |
| chg_en | output | 1 | High-voltage start-up charger enable |
| chg_low | output | 1 | Reduced charging current select |
| sw_en | output | 1 | Power switch enable |
| ilim_code | output | CODE_W | Current-limit reference code |

## Verification
The bench builds the block with CODE_W = 3 and STEP_CLKS = 4, so a full soft-start lasts only 28 clocks. This lets the bench check every step value and the hand-over to ST_RUN several times in one run, across normal start-up, post-fault hiccup attempts and restarts after a normal power-down. With the small code width, the full-scale value 7 and the exact step clocks are easy to predict. It also keeps the fault-origin flag clearing on both OFF and SOFTSTART entry within a short sequence.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    typedef enum logic [4:0] {
        ST_OFF          = 5'b00001,
        ST_CHARGE       = 5'b00010,
        ST_SOFTSTART    = 5'b00100,
        ST_RUN          = 5'b01000,
        ST_WAIT_RESTART = 5'b10000
    } seq_state_t;

endpackage

// File: rtl/startup_ramp.sv
module startup_ramp #(
    parameter int CODE_W    = 6,
    parameter int STEP_CLKS = 13492
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(STEP_CLKS - 1);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CNT_W-1:0] presc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            code  <= '0;
        end else if (!active) begin
            presc <= '0;
            code  <= '0;
        end else if (code != CODE_MAX) begin
            if (presc == CNT_LAST) begin
                presc <= '0;
                code  <= code + 1'b1;
            end else begin
                presc <= presc + 1'b1;
            end
        end
    end

    assign done = (code == CODE_MAX);

    AST_RAMP_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> (code == $past(code) || code == $past(code) + 1'b1)); // R9

    AST_RAMP_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (active && done) |=> (active ? done : 1'b1)); // R9

endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
    import startup_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vin_ok,
    input  logic       vdd_on,
    input  logic       vdd_uvlo,
    input  logic       vdd_rst,
    input  logic       fault_req,
    input  logic       ramp_done,
    output seq_state_t state,
    output logic       fault_flag
);
    seq_state_t nxt;
    logic       nxt_flag;

    always_comb begin
        nxt      = state;
        nxt_flag = fault_flag;
        unique case (state)
            ST_OFF: begin
                nxt_flag = 1'b0;
                if (vin_ok) nxt = ST_CHARGE;
            end
            ST_CHARGE: begin
                if (!vin_ok) begin
                    nxt      = ST_OFF;
                    nxt_flag = 1'b0;
                end else if (vdd_on) begin
                    nxt      = ST_SOFTSTART;
                    nxt_flag = 1'b0;
                end
            end
            ST_SOFTSTART, ST_RUN: begin
                if (vdd_uvlo && !vin_ok) begin
                    nxt      = ST_OFF;
                    nxt_flag = 1'b0;
                end else if (fault_req) begin
                    nxt      = ST_WAIT_RESTART;
                    nxt_flag = 1'b1;
                end else if (vdd_uvlo) begin
                    nxt      = ST_WAIT_RESTART;
                end else if (state == ST_SOFTSTART && ramp_done) begin
                    nxt      = ST_RUN;
                end
            end
            ST_WAIT_RESTART: begin
                if (vdd_rst) begin
                    if (vin_ok) begin
                        nxt = ST_CHARGE;
                    end else begin
                        nxt      = ST_OFF;
                        nxt_flag = 1'b0;
                    end
                end
            end
            default: begin
                nxt      = ST_OFF;
                nxt_flag = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            fault_flag <= 1'b0;
        end else begin
            state      <= nxt;
            fault_flag <= nxt_flag;
        end
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state)); // R1

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RESTART && !vdd_rst) |=> state == ST_WAIT_RESTART); // R4

    AST_FLAG_CLEAR_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOFTSTART && $past(state) == ST_CHARGE) |-> !fault_flag); // R8

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_seq_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int STEP_CLKS = 13492
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vin_ok,
    input  logic              vdd_on,
    input  logic              vdd_uvlo,
    input  logic              vdd_rst,
    input  logic              fault_req,
    output logic              chg_en,
    output logic              chg_low,
    output logic              sw_en,
    output logic [CODE_W-1:0] ilim_code
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    seq_state_t        state;
    logic              fault_flag;
    logic              ramp_done;
    logic [CODE_W-1:0] ramp_code;

    startup_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vin_ok    (vin_ok),
        .vdd_on    (vdd_on),
        .vdd_uvlo  (vdd_uvlo),
        .vdd_rst   (vdd_rst),
        .fault_req (fault_req),
        .ramp_done (ramp_done),
        .state     (state),
        .fault_flag(fault_flag)
    );

    startup_ramp #(
        .CODE_W   (CODE_W),
        .STEP_CLKS(STEP_CLKS)
    ) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .active(state == ST_SOFTSTART),
        .code  (ramp_code),
        .done  (ramp_done)
    );

    always_comb begin
        chg_en    = 1'b0;
        chg_low   = 1'b0;
        sw_en     = 1'b0;
        ilim_code = '0;
        unique case (state)
            ST_OFF, ST_WAIT_RESTART: ;
            ST_CHARGE: begin
                chg_en  = 1'b1;
                chg_low = fault_flag;
            end
            ST_SOFTSTART: begin
                sw_en     = 1'b1;
                ilim_code = ramp_code;
            end
            ST_RUN: begin
                sw_en     = 1'b1;
                ilim_code = CODE_MAX;
            end
            default: ;
        endcase
    end

    AST_NO_CHG_WHILE_SW: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_en && sw_en)); // R3

    AST_CHG_DROP_NO_VIN: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_en && !vin_ok) |=> !chg_en); // R2

    AST_SW_STOP_UVLO: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && vdd_uvlo) |=> !sw_en); // R4

    AST_RAMP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> ilim_code == '0); // R10

    AST_LOW_ONLY_CHARGING: assert property (@(posedge clk) disable iff (!rst_n)
        chg_low |-> chg_en); // R7

    AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> ilim_code == '0); // R11

endmodule

// File: tb/test_startup_seq.sv
`timescale 1ns/1ps
module test_startup_seq;
    localparam int CW   = 3;
    localparam int STEP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin_ok = 1'b0, vdd_on = 1'b0, vdd_uvlo = 1'b0, vdd_rst = 1'b0, fault_req = 1'b0;
    logic chg_en, chg_low, sw_en;
    logic [CW-1:0] ilim_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    startup_seq #(.CODE_W(CW), .STEP_CLKS(STEP)) i_startup_seq (
        .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .vdd_on(vdd_on),
        .vdd_uvlo(vdd_uvlo), .vdd_rst(vdd_rst), .fault_req(fault_req),
        .chg_en(chg_en), .chg_low(chg_low), .sw_en(sw_en), .ilim_code(ilim_code)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic outs(input string req, input int c, input int l, input int s, input int code);
        chk(req, "chg_en", int'(chg_en), c);
        chk(req, "chg_low", int'(chg_low), l);
        chk(req, "sw_en", int'(sw_en), s);
        chk(req, "ilim_code", int'(ilim_code), code);
    endtask

    // Drives a full ramp from SOFTSTART entry (vdd_on already high) to RUN
    task automatic ramp_check(input string req);
        step(1);
        vdd_on = 1'b0;
        outs(req, 0, 0, 1, 0);
        step(STEP);
        chk(req, "first step", int'(ilim_code), 1);
        step(STEP * 6);
        chk(req, "full scale", int'(ilim_code), 7);
        step(5);
        outs(req, 0, 0, 1, 7);
    endtask

    task automatic t_reset();
        outs("R1", 0, 0, 0, 0);
        step(3);
        outs("R1", 0, 0, 0, 0);
    endtask

    task automatic t_powerup();
        vin_ok = 1'b1;
        step(1);
        outs("R2", 1, 0, 0, 0);
        fault_req = 1'b1;
        step(2);
        outs("R12", 1, 0, 0, 0);
        fault_req = 1'b0;
        vdd_on = 1'b1;
        ramp_check("R9");
    endtask

    task automatic t_uvlo_stop();
        vdd_uvlo = 1'b1;
        step(1);
        outs("R4", 0, 0, 0, 0);
        fault_req = 1'b1;
        step(5);
        fault_req = 1'b0;
        outs("R12", 0, 0, 0, 0);
        vdd_rst = 1'b1;
        step(1);
        outs("R5", 1, 0, 0, 0);
        vdd_rst = 1'b0;
        vdd_uvlo = 1'b0;
        vdd_on = 1'b1;
        ramp_check("R10");
    endtask

    task automatic t_fault_hiccup();
        fault_req = 1'b1;
        step(1);
        fault_req = 1'b0;
        outs("R7", 0, 0, 0, 0);
        step(3);
        outs("R4", 0, 0, 0, 0);
        vdd_rst = 1'b1;
        step(1);
        vdd_rst = 1'b0;
        outs("R7", 1, 1, 0, 0);
        vdd_on = 1'b1;
        ramp_check("R10");
        vdd_uvlo = 1'b1;
        step(1);
        vdd_uvlo = 1'b0;
        vdd_rst = 1'b1;
        step(1);
        vdd_rst = 1'b0;
        outs("R8", 1, 0, 0, 0);
        vdd_on = 1'b1;
        ramp_check("R9");
    endtask

    task automatic t_fault_then_off();
        fault_req = 1'b1;
        step(1);
        fault_req = 1'b0;
        vin_ok = 1'b0;
        vdd_rst = 1'b1;
        step(1);
        vdd_rst = 1'b0;
        step(3);
        outs("R5", 0, 0, 0, 0);
        vin_ok = 1'b1;
        step(1);
        outs("R8", 1, 0, 0, 0);
        vdd_on = 1'b1;
        ramp_check("R11");
    endtask

    task automatic t_inhibit();
        vin_ok = 1'b0;
        vdd_uvlo = 1'b1;
        step(1);
        outs("R6", 0, 0, 0, 0);
        vdd_rst = 1'b1;
        step(5);
        outs("R6", 0, 0, 0, 0);
        vdd_uvlo = 1'b0;
        vdd_rst = 1'b0;
        vin_ok = 1'b1;
        step(1);
        outs("R2", 1, 0, 0, 0);
        vin_ok = 1'b0;
        step(1);
        outs("R2", 0, 0, 0, 0);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_powerup();
        t_uvlo_stop();
        t_fault_hiccup();
        t_fault_then_off();
        t_inhibit();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule